// File: doc/BRIEF.md
# Serial EEPROM Configuration Boot Loader

After reset this block takes the two-wire serial bus as its sole master and pulls a 64-byte configuration image out of an external nonvolatile memory. The image sits at byte offset 40h of the memory and is fetched in one sequential read burst. Each received byte goes to a local configuration register file through a one-cycle byte write port. The block drives both bus lines open-drain style: an output enable pulls the line low and a released line floats high. SDA is read back through a two-flop synchronizer.

While the bytes stream past, the block checks three things. The vendor identifier in the first two image bytes must not be all ones. The three signature bytes must match their fixed values. The base-region type byte must be one of three legal codes, and its decoded value is driven on a small output. When the burst ends, a done flag rises and stays high until the next reset, and an error flag next to it reports any check failure. A missing acknowledge from the memory on an address byte ends the run early with the error flag set and nothing written. The SCL rate is a parameterized division of the system clock.

Top module: `cfg_boot_loader`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `scl_oe`, `sda_oe`, `cfg_we`, `boot_done` and `boot_error` are 0 and `region_sel` is 0.
- R2: In each run the bus carries exactly two start conditions (SDA falling while SCL is high) and one stop condition (SDA rising while SCL is high). Outside these, SDA changes only while SCL is low, and the two line enables never change in the same clock cycle.
- R3: The bus bytes are sent in this order: start, device address with write bit (`{DEV_ADDR,0}`), word address `IMG_OFFSET` (40h), repeated start, device address with read bit (`{DEV_ADDR,1}`), then the data bytes. Each byte is 8 bits MSB first, followed by one acknowledge clock.
- R4: The master acknowledges (SDA low) the first 63 data bytes. It sends a no-acknowledge (SDA high) on the 64th, which is memory byte 7Fh, and then issues the stop.
- R5: Exactly 64 one-cycle `cfg_we` pulses occur. Pulse k carries `cfg_addr` = k, in rising order from 0, and `cfg_data` equal to memory byte 40h+k.
- R6: If image bytes 0 and 1 (memory 40h and 41h, the vendor identifier) are both FFh, `boot_error` is set. Any other vendor value, FFFEh included, is accepted.
- R7: Image byte 10h (memory 50h) decodes onto `region_sel`: 81h gives 1 (I/O space), 80h gives 2 (memory space), and 82h gives 3 (memory below 1 Mbyte). Any other value gives 0 and sets `boot_error`.
- R8: Image bytes 11h, 12h and 13h (memory 51h to 53h) must be FFh, E8h and 10h. A mismatch in any one of them sets `boot_error`.
- R9: If the memory does not acknowledge the device address byte or the word address byte, the block issues a stop, leaves both lines released, asserts `boot_done` and `boot_error`, and makes no `cfg_we` pulse.
- R10: `boot_done` rises once per run and holds until reset. `boot_error` is valid in the same cycle and is never high without `boot_done`. After done, both lines stay released and `cfg_we` stays 0.
- R11: Each SCL high pulse lasts exactly 2*CLK_DIV system clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; starts a new boot run when released |
| sda_in | input | 1 | Sampled level of the SDA line |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| cfg_we | output | 1 | One-cycle write strobe to the configuration register file |
| cfg_addr | output | 6 | Register file byte address (image offset) |
| cfg_data | output | 8 | Byte to write |
| boot_done | output | 1 | High once the boot run has ended |
| boot_error | output | 1 | Image rejected or address not acknowledged; valid with boot_done |
| region_sel | output | 2 | Decoded base-region type: 0 invalid, 1 I/O, 2 memory, 3 memory below 1 Mbyte |

## Verification
The bench builds the block with CLK_DIV=2 and keeps the defaults for device address 50h, image offset 40h and 64 image bytes. The short divider keeps a whole 64-byte burst to a few thousand cycles. That leaves room for a full burst against every vector in the image table, plus the two no-acknowledge aborts. The memory model answers at device address 50h and can withhold its acknowledge on either address byte. This reaches the accepted and rejected outcomes of every image check, the FFFEh vendor boundary, and both abort points.

// File: rtl/cfg_boot_pkg.sv
package cfg_boot_pkg;

  // bit-level bus operations
  typedef enum logic [1:0] {
    BC_START = 2'd0,
    BC_STOP  = 2'd1,
    BC_WR    = 2'd2,
    BC_RD    = 2'd3
  } bit_cmd_e;

  // decoded base-region type
  typedef enum logic [1:0] {
    RG_NONE    = 2'd0,
    RG_IO      = 2'd1,
    RG_MEM     = 2'd2,
    RG_MEM_LOW = 2'd3
  } region_e;

  // boot sequence steps
  typedef enum logic [2:0] {
    SQ_START1 = 3'd0,
    SQ_DEVW   = 3'd1,
    SQ_WADDR  = 3'd2,
    SQ_START2 = 3'd3,
    SQ_DEVR   = 3'd4,
    SQ_DATA   = 3'd5,
    SQ_STOP   = 3'd6,
    SQ_END    = 3'd7
  } seq_e;

  // image layout, offsets relative to the first image byte
  localparam int VID_LO_OFS = 0;
  localparam int VID_HI_OFS = 1;
  localparam int RGN_OFS    = 16;
  localparam int SIG_NUM    = 3;
  localparam logic [7:0] SIG_BYTES [SIG_NUM] = '{8'hFF, 8'hE8, 8'h10};

  localparam logic [7:0] RGN_CODE_IO      = 8'h81;
  localparam logic [7:0] RGN_CODE_MEM     = 8'h80;
  localparam logic [7:0] RGN_CODE_MEM_LOW = 8'h82;

endpackage

// File: rtl/cfg_boot_tick.sv
module cfg_boot_tick #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == CW'(DIV - 1)) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/cfg_boot_bitphy.sv
module cfg_boot_bitphy
  import cfg_boot_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     tick,
  input  logic     cmd_valid,
  input  bit_cmd_e cmd,
  input  logic     wr_bit,
  input  logic     sda_in,
  output logic     bit_done,
  output logic     rd_bit,
  output logic     scl_low,
  output logic     sda_low
);
  // Four quarter-bit phases per operation:
  // 0 set SDA (SCL low), 1 raise SCL, 2 start/stop edge or sample, 3 lower SCL
  logic [1:0] phase;
  logic       active;
  bit_cmd_e   cur;
  logic       cur_bit;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= '0;
      active   <= 1'b0;
      cur      <= BC_STOP;
      cur_bit  <= 1'b0;
      bit_done <= 1'b0;
      rd_bit   <= 1'b0;
      scl_low  <= 1'b0;
      sda_low  <= 1'b0;
    end else begin
      bit_done <= 1'b0;
      if (!active) begin
        if (cmd_valid) begin
          active  <= 1'b1;
          cur     <= cmd;
          cur_bit <= wr_bit;
          phase   <= '0;
        end
      end else if (tick) begin
        phase <= phase + 1'b1;
        case (phase)
          2'd0: begin
            case (cur)
              BC_START: sda_low <= 1'b0;
              BC_STOP:  sda_low <= 1'b1;
              BC_WR:    sda_low <= !cur_bit;
              default:  sda_low <= 1'b0;
            endcase
          end
          2'd1: scl_low <= 1'b0;
          2'd2: begin
            case (cur)
              BC_START: sda_low <= 1'b1;
              BC_STOP:  sda_low <= 1'b0;
              BC_RD:    rd_bit  <= sda_in;
              default:  ;
            endcase
          end
          default: begin
            if (cur != BC_STOP) scl_low <= 1'b1;
            active   <= 1'b0;
            bit_done <= 1'b1;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/cfg_boot_seq.sv
module cfg_boot_seq
  import cfg_boot_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR   = 7'h50,
  parameter logic [7:0] IMG_OFFSET = 8'h40,
  parameter int         IMG_BYTES  = 64,
  localparam int        AW         = $clog2(IMG_BYTES)
) (
  input  logic          clk,
  input  logic          rst,
  output logic          cmd_valid,
  output bit_cmd_e      cmd,
  output logic          wr_bit,
  input  logic          bit_done,
  input  logic          rd_bit,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          done,
  output logic          addr_nack
);
  seq_e          st;
  logic          pend;
  logic [3:0]    bidx;   // 0..7 data bits, 8 acknowledge
  logic [AW-1:0] cnt;
  logic [7:0]    shreg;
  logic [7:0]    tx_byte;
  logic          last;
  logic          ack_slot;

  assign last     = (cnt == AW'(IMG_BYTES - 1));
  assign ack_slot = (bidx == 4'd8);

  always_comb begin
    case (st)
      SQ_DEVW:  tx_byte = {DEV_ADDR, 1'b0};
      SQ_WADDR: tx_byte = IMG_OFFSET;
      SQ_DEVR:  tx_byte = {DEV_ADDR, 1'b1};
      default:  tx_byte = 8'h00;
    endcase
  end

  always_comb begin
    case (st)
      SQ_START1, SQ_START2: cmd = BC_START;
      SQ_STOP:              cmd = BC_STOP;
      SQ_DATA:              cmd = ack_slot ? BC_WR : BC_RD;
      default:              cmd = ack_slot ? BC_RD : BC_WR;
    endcase
    wr_bit    = (st == SQ_DATA) ? last : tx_byte[3'(4'd7 - bidx)];
    cmd_valid = !pend && (st != SQ_END);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= SQ_START1;
      pend      <= 1'b0;
      bidx      <= '0;
      cnt       <= '0;
      shreg     <= '0;
      wr_en     <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      done      <= 1'b0;
      addr_nack <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (cmd_valid) begin
        pend <= 1'b1;
      end else if (bit_done) begin
        pend <= 1'b0;
        case (st)
          SQ_START1: begin st <= SQ_DEVW; bidx <= '0; end
          SQ_START2: begin st <= SQ_DEVR; bidx <= '0; end
          SQ_DEVW, SQ_WADDR, SQ_DEVR: begin
            if (!ack_slot) begin
              bidx <= bidx + 1'b1;
            end else begin
              bidx <= '0;
              if (rd_bit) begin
                addr_nack <= 1'b1;
                st        <= SQ_STOP;
              end else if (st == SQ_DEVW) begin
                st <= SQ_WADDR;
              end else if (st == SQ_WADDR) begin
                st <= SQ_START2;
              end else begin
                st  <= SQ_DATA;
                cnt <= '0;
              end
            end
          end
          SQ_DATA: begin
            if (!ack_slot) begin
              shreg <= {shreg[6:0], rd_bit};
              bidx  <= bidx + 1'b1;
              if (bidx == 4'd7) begin
                wr_en   <= 1'b1;
                wr_addr <= cnt;
                wr_data <= {shreg[6:0], rd_bit};
              end
            end else begin
              bidx <= '0;
              if (last) st <= SQ_STOP;
              else      cnt <= cnt + 1'b1;
            end
          end
          SQ_STOP: begin
            st   <= SQ_END;
            done <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/cfg_boot_image.sv
module cfg_boot_image
  import cfg_boot_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  output logic          img_bad,
  output region_e       region
);
  logic [1:0] vid_ones;
  logic       sig_bad;

  always_ff @(posedge clk) begin
    if (rst) begin
      vid_ones <= '0;
      sig_bad  <= 1'b0;
      region   <= RG_NONE;
    end else if (wr_en) begin
      if (wr_addr == AW'(VID_LO_OFS)) vid_ones[0] <= (wr_data == 8'hFF);
      if (wr_addr == AW'(VID_HI_OFS)) vid_ones[1] <= (wr_data == 8'hFF);
      if (wr_addr == AW'(RGN_OFS)) begin
        case (wr_data)
          RGN_CODE_IO:      region <= RG_IO;
          RGN_CODE_MEM:     region <= RG_MEM;
          RGN_CODE_MEM_LOW: region <= RG_MEM_LOW;
          default:          region <= RG_NONE;
        endcase
      end
      for (int i = 0; i < SIG_NUM; i++) begin
        if (wr_addr == AW'(RGN_OFS + 1 + i) && wr_data != SIG_BYTES[i])
          sig_bad <= 1'b1;
      end
    end
  end

  assign img_bad = (&vid_ones) | sig_bad | (region == RG_NONE);
endmodule

// File: rtl/cfg_boot_loader.sv
module cfg_boot_loader
  import cfg_boot_pkg::*;
#(
  parameter int         CLK_DIV    = 4,
  parameter logic [6:0] DEV_ADDR   = 7'h50,
  parameter logic [7:0] IMG_OFFSET = 8'h40,
  parameter int         IMG_BYTES  = 64,
  localparam int        AW         = $clog2(IMG_BYTES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sda_in,
  output logic          scl_oe,
  output logic          sda_oe,
  output logic          cfg_we,
  output logic [AW-1:0] cfg_addr,
  output logic [7:0]    cfg_data,
  output logic          boot_done,
  output logic          boot_error,
  output logic [1:0]    region_sel
);
  logic     tick;
  logic     sda_s1, sda_s2;
  logic     cmd_valid, wr_bit, bit_done, rd_bit;
  bit_cmd_e cmd;
  logic     seq_done, addr_nack, img_bad;
  region_e  region;

  always_ff @(posedge clk) begin
    if (rst) begin
      sda_s1     <= 1'b1;
      sda_s2     <= 1'b1;
      boot_done  <= 1'b0;
      boot_error <= 1'b0;
    end else begin
      sda_s1     <= sda_in;
      sda_s2     <= sda_s1;
      boot_done  <= seq_done;
      boot_error <= seq_done & (addr_nack | img_bad);
    end
  end

  cfg_boot_tick #(.DIV(CLK_DIV)) u_tick (
    .clk (clk),
    .rst (rst),
    .tick(tick)
  );

  cfg_boot_bitphy u_phy (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .cmd_valid(cmd_valid),
    .cmd      (cmd),
    .wr_bit   (wr_bit),
    .sda_in   (sda_s2),
    .bit_done (bit_done),
    .rd_bit   (rd_bit),
    .scl_low  (scl_oe),
    .sda_low  (sda_oe)
  );

  cfg_boot_seq #(
    .DEV_ADDR  (DEV_ADDR),
    .IMG_OFFSET(IMG_OFFSET),
    .IMG_BYTES (IMG_BYTES)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .cmd_valid(cmd_valid),
    .cmd      (cmd),
    .wr_bit   (wr_bit),
    .bit_done (bit_done),
    .rd_bit   (rd_bit),
    .wr_en    (cfg_we),
    .wr_addr  (cfg_addr),
    .wr_data  (cfg_data),
    .done     (seq_done),
    .addr_nack(addr_nack)
  );

  cfg_boot_image #(.AW(AW)) u_img (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (cfg_we),
    .wr_addr(cfg_addr),
    .wr_data(cfg_data),
    .img_bad(img_bad),
    .region (region)
  );

  assign region_sel = region;
endmodule

// File: rtl/cfg_boot_loader_chk.sv
module cfg_boot_loader_chk #(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst,
  input logic          scl_oe,
  input logic          sda_oe,
  input logic          cfg_we,
  input logic [AW-1:0] cfg_addr,
  input logic          boot_done,
  input logic          boot_error,
  input logic [1:0]    region_sel
);
  logic [AW-1:0] prev_addr;
  logic          wr_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_addr <= '0;
      wr_seen   <= 1'b0;
    end else if (cfg_we) begin
      prev_addr <= cfg_addr;
      wr_seen   <= 1'b1;
    end
  end

  AST_LINES_SPLIT: assert property (@(posedge clk) disable iff (rst) !(!$stable(scl_oe) && !$stable(sda_oe))); // R2
  AST_WE_SINGLE: assert property (@(posedge clk) disable iff (rst) cfg_we |=> !cfg_we); // R5
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst) (cfg_we && wr_seen) |-> (cfg_addr == prev_addr + 1'b1)); // R5
  AST_FIRST_ADDR: assert property (@(posedge clk) disable iff (rst) (cfg_we && !wr_seen) |-> (cfg_addr == '0)); // R5
  AST_REGION_BAD: assert property (@(posedge clk) disable iff (rst) (boot_done && region_sel == 2'd0) |-> boot_error); // R7
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst) boot_done |=> boot_done); // R10
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst) boot_done |-> (!scl_oe && !sda_oe && !cfg_we)); // R10
  AST_ERR_DONE: assert property (@(posedge clk) disable iff (rst) boot_error |-> boot_done); // R10
endmodule

bind cfg_boot_loader cfg_boot_loader_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .scl_oe    (scl_oe),
  .sda_oe    (sda_oe),
  .cfg_we    (cfg_we),
  .cfg_addr  (cfg_addr),
  .boot_done (boot_done),
  .boot_error(boot_error),
  .region_sel(region_sel)
);

// File: tb/cfg_boot_loader_test.sv
module cfg_boot_loader_test;
  localparam int         DIV   = 2;
  localparam logic [6:0] DEV   = 7'h50;
  localparam int         NB    = 64;
  localparam int         M_IDLE = 0, M_ADDR = 1, M_WADDR = 2, M_READ = 3;

  typedef struct packed {
    logic [15:0] vid;
    logic [7:0]  rgn;
    logic [7:0]  s0;
    logic [7:0]  s1;
    logic [7:0]  s2;
    logic        err;
    logic [1:0]  rsel;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{16'h10B5, 8'h81, 8'hFF, 8'hE8, 8'h10, 1'b0, 2'd1},
    '{16'h1234, 8'h80, 8'hFF, 8'hE8, 8'h10, 1'b0, 2'd2},
    '{16'hABCD, 8'h82, 8'hFF, 8'hE8, 8'h10, 1'b0, 2'd3},
    '{16'hFFFF, 8'h81, 8'hFF, 8'hE8, 8'h10, 1'b1, 2'd1},
    '{16'hFFFE, 8'h81, 8'hFF, 8'hE8, 8'h10, 1'b0, 2'd1},
    '{16'h10B5, 8'h83, 8'hFF, 8'hE8, 8'h10, 1'b1, 2'd0},
    '{16'h10B5, 8'h81, 8'hFF, 8'hE8, 8'h11, 1'b1, 2'd1},
    '{16'h10B5, 8'h80, 8'hFE, 8'hE8, 8'h10, 1'b1, 2'd2},
    '{16'h00FF, 8'h80, 8'hFF, 8'h00, 8'h10, 1'b1, 2'd2}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sda_in;
  logic       scl_oe, sda_oe, cfg_we, boot_done, boot_error;
  logic [5:0] cfg_addr;
  logic [7:0] cfg_data;
  logic [1:0] region_sel;

  always #4 clk = ~clk;

  cfg_boot_loader #(.CLK_DIV(DIV), .DEV_ADDR(DEV)) uut (
    .clk(clk), .rst(rst), .sda_in(sda_in),
    .scl_oe(scl_oe), .sda_oe(sda_oe),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .boot_done(boot_done), .boot_error(boot_error), .region_sel(region_sel)
  );

  // bus wiring with the memory model
  logic slv_low;
  logic scl_bus, sda_bus;
  assign scl_bus = !scl_oe;
  assign sda_bus = !(sda_oe | slv_low);
  assign sda_in  = sda_bus;

  logic [7:0] mem [256];
  logic [7:0] rf  [NB];
  logic       nack_dev, nack_waddr;

  // memory model + monitor, one process, sampled on the falling clock edge
  logic       pscl, psda, sactive, rw_rd, got_nack;
  int         mode, bcnt, nstart, nstop, nhdr, ack_cnt, wcount, order_bad;
  int         hcnt, hbad, hpulses;
  logic       hmeas;
  logic [7:0] sh, ptr, nack_at;
  logic [7:0] hdr [4];
  logic [5:0] exp_addr;

  always @(negedge clk) begin
    if (rst) begin
      pscl <= 1'b1; psda <= 1'b1; sactive <= 1'b0; slv_low <= 1'b0;
      mode <= M_IDLE; bcnt <= 0; nstart <= 0; nstop <= 0; nhdr <= 0;
      ack_cnt <= 0; nack_at <= 8'h00; got_nack <= 1'b0; rw_rd <= 1'b0;
      sh <= 8'h00; ptr <= 8'h00; wcount <= 0; order_bad <= 0; exp_addr <= 6'd0;
      hcnt <= 0; hmeas <= 1'b0;
    end else begin
      pscl <= scl_bus;
      psda <= sda_bus;
      if (cfg_we) begin
        rf[cfg_addr] <= cfg_data;
        wcount <= wcount + 1;
        if (cfg_addr != exp_addr) order_bad <= order_bad + 1;
        exp_addr <= exp_addr + 6'd1;
      end
      if (!pscl && scl_bus) begin
        hmeas <= 1'b1; hcnt <= 1;
      end else if (scl_bus && hmeas) begin
        hcnt <= hcnt + 1;
      end else if (!scl_bus && hmeas) begin
        hmeas <= 1'b0; hpulses <= hpulses + 1;
        if (hcnt != 2 * DIV) hbad <= hbad + 1;
      end
      if (scl_bus && pscl && psda && !sda_bus) begin
        sactive <= 1'b1; mode <= M_ADDR; bcnt <= 0; slv_low <= 1'b0; nstart <= nstart + 1;
      end else if (scl_bus && pscl && !psda && sda_bus) begin
        sactive <= 1'b0; slv_low <= 1'b0; nstop <= nstop + 1;
      end else if (sactive && scl_bus && !pscl) begin
        bcnt <= bcnt + 1;
        if (mode != M_READ && bcnt < 8) sh <= {sh[6:0], sda_bus};
        if (mode == M_READ && bcnt == 8) got_nack <= sda_bus;
      end else if (sactive && !scl_bus && pscl) begin
        if (mode == M_ADDR || mode == M_WADDR) begin
          if (bcnt == 8) begin
            if (nhdr < 4) hdr[nhdr] <= sh;
            nhdr <= nhdr + 1;
            rw_rd <= sh[0];
            if ((mode == M_ADDR && sh[7:1] == DEV && !nack_dev) || (mode == M_WADDR && !nack_waddr))
              slv_low <= 1'b1;
            else
              mode <= M_IDLE;
          end else if (bcnt == 9) begin
            bcnt <= 0;
            slv_low <= 1'b0;
            if (mode == M_ADDR && rw_rd) begin
              mode <= M_READ;
              slv_low <= !mem[ptr][7];
            end else if (mode == M_ADDR) begin
              mode <= M_WADDR;
            end else begin
              ptr <= sh;
              mode <= M_IDLE;
            end
          end
        end else if (mode == M_READ) begin
          if (bcnt >= 1 && bcnt <= 7) begin
            slv_low <= !mem[ptr][3'(7 - bcnt)];
          end else if (bcnt == 8) begin
            slv_low <= 1'b0;
          end else if (bcnt == 9) begin
            bcnt <= 0;
            if (got_nack) begin
              mode <= M_IDLE; nack_at <= ptr;
            end else begin
              ack_cnt <= ack_cnt + 1;
              ptr <= ptr + 8'd1;
              slv_low <= !mem[8'(ptr + 8'd1)][7];
            end
          end
        end
      end
    end
  end

  initial begin hbad = 0; hpulses = 0; end

  // watchdog
  int   cyc = 0;
  logic timeout = 1'b0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc >= 190000) timeout <= 1'b1;
  end

  int errors = 0;
  int checks = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load_image(input vec_t v);
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
    mem[8'h40] = v.vid[7:0];
    mem[8'h41] = v.vid[15:8];
    mem[8'h50] = v.rgn;
    mem[8'h51] = v.s0;
    mem[8'h52] = v.s1;
    mem[8'h53] = v.s2;
  endtask

  task automatic run_boot();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    while (!boot_done && !timeout) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    nack_dev = 1'b0;
    nack_waddr = 1'b0;
    load_image(VECS[0]);

    // table of image vectors
    for (int v = 0; v < NV; v++) begin
      int bad;
      load_image(VECS[v]);
      run_boot();
      chk(boot_done === 1'b1, "R10 done", 32'(boot_done), 1);
      chk(boot_error === VECS[v].err, $sformatf("R6 R7 R8 error vector %0d", v), 32'(boot_error), 32'(VECS[v].err));
      chk(region_sel === VECS[v].rsel, $sformatf("R7 region vector %0d", v), 32'(region_sel), 32'(VECS[v].rsel));
      chk(wcount == NB && order_bad == 0, "R5 write count/order", 32'(wcount), NB);
      bad = 0;
      for (int k = 0; k < NB; k++) if (rf[k] !== mem[8'h40 + k]) bad++;
      chk(bad == 0, "R5 register file contents", 32'(bad), 0);
      chk(nhdr == 3 && hdr[0] == {DEV, 1'b0} && hdr[1] == 8'h40 && hdr[2] == {DEV, 1'b1},
          "R3 header bytes", {hdr[0], hdr[1], hdr[2], 8'(nhdr)}, {DEV, 1'b0, 8'h40, DEV, 1'b1, 8'd3});
      chk(ack_cnt == NB - 1 && nack_at == 8'h7F, "R4 ack/nack", {16'(ack_cnt), 8'h0, nack_at}, {16'(NB - 1), 8'h0, 8'h7F});
      chk(nstart == 2 && nstop == 1, "R2 start/stop count", {16'(nstart), 16'(nstop)}, {16'd2, 16'd1});
      chk(!scl_oe && !sda_oe, "R10 lines released", {30'd0, scl_oe, sda_oe}, 0);
    end

    // R11: SCL high time over all runs
    chk(hbad == 0 && hpulses > 0, "R11 SCL high width", 32'(hbad), 0);

    // R10: done holds, no further writes
    begin
      int w0;
      w0 = wcount;
      repeat (200) @(negedge clk);
      chk(boot_done === 1'b1 && wcount == w0 && !cfg_we, "R10 done held", {31'd0, boot_done}, 1);
    end

    // R1: reset state
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk({scl_oe, sda_oe, cfg_we, boot_done, boot_error, region_sel} == 7'd0, "R1 during reset",
        {25'd0, scl_oe, sda_oe, cfg_we, boot_done, boot_error, region_sel}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk({scl_oe, sda_oe, cfg_we, boot_done, boot_error, region_sel} == 7'd0, "R1 first cycle after reset",
        {25'd0, scl_oe, sda_oe, cfg_we, boot_done, boot_error, region_sel}, 0);

    // R9: device address not acknowledged
    load_image(VECS[0]);
    nack_dev = 1'b1;
    run_boot();
    chk(boot_done && boot_error, "R9 device nack done+error", {30'd0, boot_done, boot_error}, 3);
    chk(wcount == 0 && nhdr == 1 && nstop == 1, "R9 device nack no writes", {16'(wcount), 8'(nhdr), 8'(nstop)}, {16'd0, 8'd1, 8'd1});
    chk(!scl_oe && !sda_oe, "R9 device nack released", {30'd0, scl_oe, sda_oe}, 0);
    nack_dev = 1'b0;

    // R9: word address not acknowledged
    nack_waddr = 1'b1;
    run_boot();
    chk(boot_done && boot_error, "R9 word nack done+error", {30'd0, boot_done, boot_error}, 3);
    chk(wcount == 0 && nhdr == 2 && nstop == 1, "R9 word nack no writes", {16'(wcount), 8'(nhdr), 8'(nstop)}, {16'd0, 8'd2, 8'd1});
    nack_waddr = 1'b0;

    if (timeout) chk(1'b0, "WATCHDOG", 32'(cyc), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule